// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Bus Master

This block is a bus master for an external asynchronous memory or peripheral bus whose address and data share one 16-bit pin group. Internal logic asks for one read or one write at a time. Each request carries a 24-bit address, a data word and a width mode flag. The block then walks the external pins through address latch, strobe and recovery phases. It controls the output enable of the shared pins, and it reports completion with a one-cycle done pulse. A read returns its data together with that pulse.

The width mode selects the device type. Halfword mode reaches 16-bit devices and presents 16 address bits in a single latch pulse. Byte mode reaches 8-bit devices and presents 24 address bits in two latch pulses: the upper byte first, then the lower halfword. A latch-enable cycle is always followed by a gap cycle in which the address is still driven and the latch enable is low. A strobe therefore never starts while the latch enable is high. Each data unit takes a strobe of `STB_CYC` cycles plus one recovery cycle, which is three core cycles at the default setting.

The controller has seven states: IDLE, ALE_UP, GAP_UP, ALE_LOW, GAP_LOW, STROBE and RECOVER. Its transitions are:
- IDLE goes to ALE_UP on an accepted byte-mode request.
- IDLE goes to ALE_LOW on an accepted halfword-mode request.
- IDLE stays in IDLE while no request is accepted.
- ALE_UP goes to GAP_UP, GAP_UP goes to ALE_LOW, ALE_LOW goes to GAP_LOW, and GAP_LOW goes to STROBE.
- STROBE stays in STROBE until its cycle count reaches `STB_CYC`, then goes to RECOVER.
- RECOVER goes to IDLE.

Top module: `pbus_master`

## Requirements
- R1: While reset is asserted (active low) and after it is released, the idle outputs are: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0 and `req_ready`=1.
- R2: `req_ready` is 1 only in IDLE. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. A `req_valid` seen while the block is busy has no effect on the pins or on the running transfer.
- R3: In halfword mode (`req_byte_mode`=0) the cycle after acceptance shows `ale`=1 with `ad_out`=addr[15:0] and `ad_oe`=1. The next cycle shows `ale`=0 with the same address still driven. Address bits [23:16] are ignored.
- R4: In byte mode (`req_byte_mode`=1), acceptance is followed by four cycles. The first has `ale`=1 and `ad_out`={8'h00, addr[23:16]}. The second has `ale`=0 and the same value. The third has `ale`=1 and `ad_out`=addr[15:0]. The fourth has `ale`=0 and addr[15:0].
- R5: `rd_n` and `wr_n` are active low and are never low together. A strobe is low for exactly `STB_CYC` (default 2) consecutive cycles, and `ale` is 0 in the cycle before a strobe falls.
- R6: A write drives `ad_oe`=1 throughout the strobe and the following recovery cycle. The value driven is `ad_out`=wdata in halfword mode, or {8'h00, wdata[7:0]} in byte mode.
- R7: A read holds `ad_oe`=0 during the strobe and the recovery cycle. `ad_in` is sampled on the clock edge that ends the last strobe cycle. `rdata` is the full sample in halfword mode, or {8'h00, sample[7:0]} in byte mode.
- R8: `done` is 1 for exactly the single recovery cycle after the strobe, and `rdata` is valid in that cycle. The block is back in IDLE the cycle after `done`. A transfer therefore takes 5 cycles in halfword mode and 7 cycles in byte mode, counted from the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte_mode | input | 1 | 1 = byte-wide device, 24-bit address; 0 = halfword device, 16-bit address |
| req_addr | input | 24 | Target address |
| req_wdata | input | 16 | Write data (low byte only in byte mode) |
| req_ready | output | 1 | Block idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| ad_out | output | 16 | Value driven onto the shared pins |
| ad_oe | output | 1 | Output enable for the shared pins |
| ad_in | input | 16 | Value seen on the shared pins |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions assume that the requester treats `req_ready` as the only permission to issue. `req_valid` may still be raised while the block is busy, and the properties check that such a request is ignored rather than assume it never happens. The checks on the strobes, the latch enable and bus release make no assumption about `ad_in`. The stimulus raises stray requests only in the middle of a transfer and drops them before the block can return to IDLE. During reads it places a wrong value on `ad_in` in the early strobe cycle, so that a sample taken too early shows up as a data mismatch.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE_UP,
        ST_GAP_UP,
        ST_ALE_LOW,
        ST_GAP_LOW,
        ST_STROBE,
        ST_RECOVER
    } pbus_state_e;
endpackage

// File: rtl/pbus_fsm.sv
module pbus_fsm
    import pbus_pkg::*;
#(
    parameter int STB_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        byte_mode_in,
    output pbus_state_e state,
    output logic        strobe_last
);
    localparam int CNT_W = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_CYC - 1);

    pbus_state_e      state_nx;
    logic [CNT_W-1:0] cnt_q;

    assign strobe_last = (state == ST_STROBE) && (cnt_q == CNT_LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = byte_mode_in ? ST_ALE_UP : ST_ALE_LOW;
            ST_ALE_UP:  state_nx = ST_GAP_UP;
            ST_GAP_UP:  state_nx = ST_ALE_LOW;
            ST_ALE_LOW: state_nx = ST_GAP_LOW;
            ST_GAP_LOW: state_nx = ST_STROBE;
            ST_STROBE:  if (strobe_last) state_nx = ST_RECOVER;
            ST_RECOVER: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_STROBE && !strobe_last)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end
endmodule

// File: rtl/pbus_req_reg.sv
module pbus_req_reg #(
    parameter int ADDR_W = 24,
    parameter int AD_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic              req_byte_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AD_W-1:0]   req_wdata,
    input  logic              strobe_last,
    input  logic [AD_W-1:0]   ad_in,
    output logic              write_q,
    output logic              byte_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [AD_W-1:0]   wdata_q,
    output logic [AD_W-1:0]   rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            byte_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                write_q <= req_write;
                byte_q  <= req_byte_mode;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (strobe_last && !write_q) begin
                if (byte_q)
                    rdata_q <= {{(AD_W-BYTE_W){1'b0}}, ad_in[BYTE_W-1:0]};
                else
                    rdata_q <= ad_in;
            end
        end
    end
endmodule

// File: rtl/pbus_pin_drive.sv
module pbus_pin_drive
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int AD_W   = 16,
    parameter int BYTE_W = 8
) (
    input  pbus_state_e       state,
    input  logic              write_q,
    input  logic              byte_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [AD_W-1:0]   wdata_q,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ad_oe,
    output logic [AD_W-1:0]   ad_out,
    output logic              done,
    output logic              ready
);
    localparam int HI_W = ADDR_W - AD_W;

    logic [AD_W-1:0] addr_hi_word;
    logic [AD_W-1:0] addr_lo_word;
    logic [AD_W-1:0] data_word;

    assign addr_hi_word = {{(AD_W-HI_W){1'b0}}, addr_q[ADDR_W-1:AD_W]};
    assign addr_lo_word = addr_q[AD_W-1:0];
    assign data_word    = byte_q ? {{(AD_W-BYTE_W){1'b0}}, wdata_q[BYTE_W-1:0]} : wdata_q;

    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '0;
        done   = 1'b0;
        ready  = 1'b0;
        unique case (state)
            ST_IDLE: ready = 1'b1;
            ST_ALE_UP: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_hi_word;
            end
            ST_GAP_UP: begin
                ad_oe  = 1'b1;
                ad_out = addr_hi_word;
            end
            ST_ALE_LOW: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_lo_word;
            end
            ST_GAP_LOW: begin
                ad_oe  = 1'b1;
                ad_out = addr_lo_word;
            end
            ST_STROBE: begin
                rd_n  = write_q;
                wr_n  = !write_q;
                ad_oe = write_q;
                if (write_q) ad_out = data_word;
            end
            ST_RECOVER: begin
                done  = 1'b1;
                ad_oe = write_q;
                if (write_q) ad_out = data_word;
            end
            default: ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int AD_W    = 16,
    parameter int BYTE_W  = 8,
    parameter int STB_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_byte_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AD_W-1:0]   req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [AD_W-1:0]   rdata,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    input  logic [AD_W-1:0]   ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);
    pbus_state_e       state;
    logic              strobe_last;
    logic              accept;
    logic              write_q;
    logic              byte_q;
    logic [ADDR_W-1:0] addr_q;
    logic [AD_W-1:0]   wdata_q;

    assign accept = req_valid && req_ready;

    pbus_fsm #(.STB_CYC(STB_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .byte_mode_in(req_byte_mode),
        .state       (state),
        .strobe_last (strobe_last)
    );

    pbus_req_reg #(.ADDR_W(ADDR_W), .AD_W(AD_W), .BYTE_W(BYTE_W)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .req_write    (req_write),
        .req_byte_mode(req_byte_mode),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .strobe_last  (strobe_last),
        .ad_in        (ad_in),
        .write_q      (write_q),
        .byte_q       (byte_q),
        .addr_q       (addr_q),
        .wdata_q      (wdata_q),
        .rdata_q      (rdata)
    );

    pbus_pin_drive #(.ADDR_W(ADDR_W), .AD_W(AD_W), .BYTE_W(BYTE_W)) u_pins (
        .state  (state),
        .write_q(write_q),
        .byte_q (byte_q),
        .addr_q (addr_q),
        .wdata_q(wdata_q),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .ad_oe  (ad_oe),
        .ad_out (ad_out),
        .done   (done),
        .ready  (req_ready)
    );
endmodule

// File: rtl/pbus_checker.sv
module pbus_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe
);
    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_ale_clear_before_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(ale));

    assert_ale_clear_before_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> !$past(ale));

    assert_read_bus_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_write_bus_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    assert_accept_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_busy_no_done_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!done && rd_n && wr_n));

    assert_ale_drives_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n && wr_n));
endmodule

bind pbus_master pbus_checker u_pbus_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .done     (done),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ad_oe    (ad_oe)
);

// File: tb/tb_pbus_master.sv
module tb_pbus_master;
    localparam int CLK_PERIOD = 10;
    localparam int STB        = 2;

    typedef struct {
        logic        ale, rd_n, wr_n, oe, done, ready, chk_rd;
        logic [15:0] ad;
        logic [15:0] rdata;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0, req_byte_mode = 0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done, ad_oe, ale, rd_n, wr_n;
    logic [15:0] rdata, ad_out;
    logic [15:0] ad_in = 16'h1111;
    logic [15:0] dev_word = '0;

    exp_t exp_q[$];
    int   checks = 0, errors = 0, cycles = 0, rd_low = 0;
    bit   finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_master dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_byte_mode(req_byte_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    // Reference: one expected pin vector per cycle; empty queue means idle.
    always @(negedge clk) begin
        exp_t e;
        bit   bad;
        if (exp_q.size() != 0) e = exp_q.pop_front();
        else begin
            e.ale = 0; e.rd_n = 1; e.wr_n = 1; e.oe = 0; e.done = 0; e.ready = 1;
            e.chk_rd = 0; e.ad = '0; e.rdata = '0;
            e.tag = rst_n ? "R2 idle" : "R1 reset";
        end
        bad = (ale !== e.ale) || (rd_n !== e.rd_n) || (wr_n !== e.wr_n) ||
              (ad_oe !== e.oe) || (done !== e.done) || (req_ready !== e.ready) ||
              (e.oe && ad_out !== e.ad) || (e.chk_rd && rdata !== e.rdata);
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s t=%0t: got ale=%b rd_n=%b wr_n=%b oe=%b ad=%h done=%b rdy=%b rdata=%h | exp ale=%b rd_n=%b wr_n=%b oe=%b ad=%h done=%b rdy=%b rdata=%h",
                     e.tag, $time, ale, rd_n, wr_n, ad_oe, ad_out, done, req_ready, rdata,
                     e.ale, e.rd_n, e.wr_n, e.oe, e.ad, e.done, e.ready, e.rdata);
        end
        // Device model: wrong value early in RD, true value in the last strobe cycle (R7)
        if (rd_n === 1'b0) begin
            rd_low++;
            ad_in = (rd_low == STB) ? dev_word : ~dev_word;
        end else begin
            rd_low = 0;
            ad_in = 16'hC0DE;
        end
    end

    task automatic push(input logic a, input logic r, input logic w, input logic oe,
                        input logic [15:0] ad, input logic dn, input logic chk,
                        input logic [15:0] rd, input string tag);
        exp_t e;
        e.ale = a; e.rd_n = r; e.wr_n = w; e.oe = oe; e.ad = ad; e.done = dn;
        e.ready = 0; e.chk_rd = chk; e.rdata = rd; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic xfer(input logic wr, input logic bm, input logic [23:0] addr,
                        input logic [15:0] wd, input bit stray);
        logic [15:0] data, rexp;
        @(posedge clk); #2;
        req_valid = 1; req_write = wr; req_byte_mode = bm; req_addr = addr; req_wdata = wd;
        dev_word = addr[15:0] ^ 16'h5A3C;
        @(posedge clk); #2;
        data = bm ? {8'h00, wd[7:0]} : wd;
        rexp = bm ? {8'h00, dev_word[7:0]} : dev_word;
        if (bm) begin
            push(1, 1, 1, 1, {8'h00, addr[23:16]}, 0, 0, '0, "R4 ale up");
            push(0, 1, 1, 1, {8'h00, addr[23:16]}, 0, 0, '0, "R4 gap up");
        end
        push(1, 1, 1, 1, addr[15:0], 0, 0, '0, bm ? "R4 ale low" : "R3 ale");
        push(0, 1, 1, 1, addr[15:0], 0, 0, '0, bm ? "R4 gap low" : "R3 gap");
        for (int i = 0; i < STB; i++)
            push(0, wr, !wr, wr, data, 0, 0, '0, wr ? "R6 write strobe" : "R7 read strobe");
        push(0, 1, 1, wr, data, 1, !wr, rexp, "R8 done");
        if (stray) begin
            // R2: requests while busy must not disturb the transfer
            req_write = !wr; req_byte_mode = !bm; req_addr = ~addr; req_wdata = ~wd;
            @(posedge clk); #2;
            @(posedge clk); #2;
        end
        req_valid = 0;
        while (exp_q.size() != 0) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        xfer(1, 0, 24'hAB1234, 16'hBEEF, 0);  // R3 upper bits ignored, R6
        xfer(0, 0, 24'h000F0F, 16'h0000, 0);  // R7 halfword read
        xfer(1, 1, 24'h5AC3E1, 16'h77A5, 0);  // R4 byte write
        xfer(0, 1, 24'hFF0102, 16'h0000, 0);  // R4 R7 byte read
        xfer(1, 0, 24'h001357, 16'h2468, 1);  // R2 stray while busy
        xfer(0, 1, 24'h12ABCD, 16'h0000, 1);  // R2 stray during byte read
        xfer(0, 0, 24'h00FFFF, 16'h0000, 0);  // R5 R8 back to back
        xfer(1, 1, 24'h000000, 16'hFFFF, 0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule